// File: doc/BRIEF.md
# Automatic Line-Activity Power Controller

This block is the digital control core of a multi-channel serial line transceiver. Each receiver channel supplies one activity flag, which is high while the remote end drives the line to a valid level and low while the input rests near ground. From these flags and two mode pins, a shutdown pin and a force-on pin, the block produces a line-present status output and the enables for the line drivers, the receivers and the charge pump.

The activity flags are synchronized and OR-ed together. A debounce counter decides the status output. A second tracker puts the drivers into standby after a long quiet period and wakes them after the line has been continuously active for a wake period. A rail-settling counter holds the drivers off after each exit from shutdown until the pump rails are taken as valid. The shutdown pin has the highest priority, then the force-on pin, then automatic mode. Every delay is a clock-cycle parameter: `STS_DLY`, `IDLE_DLY`, `WAKE_DLY` and `SETTLE_DLY`. The mode pins are assumed to be synchronous to `clk`.

Top module: `line_power_ctrl`

## Requirements
- R1: Right after reset, `status` and `drv_en` are 0, and `rcv_en` and `pump_en` equal `shdn_n`. The line tracker starts in standby, so with `force_on` low `drv_en` stays 0 after the rails settle and before any activity.
- R2: When any channel of `line_act` goes from all-low to active, `status` rises exactly STS_DLY+2 clock edges later (2 synchronizer stages plus STS_DLY cycles of debounce). It is still 0 one edge earlier.
- R3: When all channels fall inactive, `status` falls exactly STS_DLY+2 edges later. A change in line activity that lasts fewer than STS_DLY cycles leaves `status` unchanged.
- R4: `status` keeps tracking line activity, with the same timing, while the block is shut down.
- R5: With `shdn_n` = 0, `drv_en`, `rcv_en` and `pump_en` are all 0 within the same cycle, whatever `force_on` and `line_act` are.
- R6: With `shdn_n` = 1 and `force_on` = 1, `drv_en` is 1 once the rails have settled, even when no line activity is present for any length of time.
- R7: In automatic mode (`shdn_n` = 1, `force_on` = 0), when all channels stay inactive, `drv_en` falls exactly IDLE_DLY+2 edges after the last activity ends. `rcv_en` and `pump_en` stay 1.
- R8: Any activity on any channel restarts the quiet-period count. Standby is then entered IDLE_DLY+2 edges after the last active input ends, not earlier.
- R9: From standby in automatic mode, `drv_en` rises exactly WAKE_DLY+2 edges after continuous activity begins. If the activity stops before then, the wake count restarts from zero.
- R10: After `shdn_n` rises, `drv_en` stays 0 for SETTLE_DLY edges and may rise at the SETTLE_DLY-th edge. Any cycle with `shdn_n` = 0 invalidates the rails again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_act | input | NCH | Per-channel activity flag, 1 = valid line signal |
| shdn_n | input | 1 | 0 = shut down drivers, receivers and pump |
| force_on | input | 1 | 1 = keep drivers on regardless of activity (needs shdn_n = 1) |
| status | output | 1 | Debounced line-present indication |
| drv_en | output | 1 | Line driver enable |
| rcv_en | output | 1 | Receiver enable |
| pump_en | output | 1 | Charge pump enable |

## Verification
On every cycle, the assertions check these rules: `status` only ever moves toward the synchronized line activity, the tracker never leaves standby without activity and never enters standby while activity is present, a driver enable always comes with receivers and pump on, and the rails are lost after a shutdown cycle. The exact latencies can only be shown by the bench's timed scenarios: status debounce, quiet period, wake period and settling. The same holds for filtering of short glitches, restart of the counts on interrupted activity or quiet, and status tracking during shutdown.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
package lpc_pkg;
  typedef enum logic [1:0] {PM_OFF, PM_FORCED, PM_AUTO} pwr_mode_t;

  // pin priority: shutdown over force-on over automatic
  function automatic pwr_mode_t pick_mode(input logic shdn_n, input logic force_on);
    if (!shdn_n)      return PM_OFF;
    else if (force_on) return PM_FORCED;
    else               return PM_AUTO;
  endfunction

  // bits to count 0 .. lim-1
  function automatic int unsigned cnt_bits(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/act_sync.sv
`timescale 1ns/1ps
module act_sync #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] raw,
  output logic [NCH-1:0] synced
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= raw[g];
        sync_q <= meta_q;
      end
    end
    assign synced[g] = sync_q;
  end
endmodule

// File: rtl/status_filter.sv
`timescale 1ns/1ps
module status_filter #(
  parameter int unsigned DLY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_act,
  output logic status
);
  localparam int unsigned CW = lpc_pkg::cnt_bits(DLY);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          differs, flip_now;

  assign differs  = (any_act != status);
  assign flip_now = differs && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      status <= 1'b0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (flip_now) begin
      cnt_q  <= '0;
      status <= any_act;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  status_moves_toward_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> (status == $past(any_act)));
  // R3
  status_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/line_track.sv
`timescale 1ns/1ps
module line_track #(
  parameter int unsigned IDLE_DLY = 25,
  parameter int unsigned WAKE_DLY = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_act,
  output logic line_up
);
  localparam int unsigned CW = lpc_pkg::cnt_bits(lpc_pkg::max2(IDLE_DLY, WAKE_DLY));
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_DLY - 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_DLY - 1);

  // one shared counter: quiet time while up, active time while in standby
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_now;
  logic          settled, limit_hit;

  assign lim_now   = line_up ? IDLE_LAST : WAKE_LAST;
  assign settled   = (any_act == line_up);
  assign limit_hit = !settled && (cnt_q == lim_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      line_up <= 1'b0;
    end else if (settled) begin
      cnt_q <= '0;
    end else if (limit_hit) begin
      cnt_q   <= '0;
      line_up <= any_act;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  no_standby_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_act && line_up) |=> line_up);
  // R9
  wake_needs_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_up) |-> $past(any_act));
  // R7
  standby_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_up) |-> !$past(any_act));
endmodule

// File: rtl/rail_settle.sv
`timescale 1ns/1ps
module rail_settle #(
  parameter int unsigned DLY = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic rails_ok
);
  localparam int unsigned CW = lpc_pkg::cnt_bits(DLY);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          done_now;

  assign done_now = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rails_ok <= 1'b0;
    end else if (!pwr_on) begin
      cnt_q    <= '0;
      rails_ok <= 1'b0;
    end else if (!rails_ok) begin
      if (done_now) begin
        cnt_q    <= '0;
        rails_ok <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R10
  rails_lost_on_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !rails_ok);
  // R10
  rails_rise_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rails_ok) |-> $past(pwr_on));
endmodule

// File: rtl/line_power_ctrl.sv
`timescale 1ns/1ps
module line_power_ctrl #(
  parameter int          NCH        = 3,
  parameter int unsigned STS_DLY    = 5,
  parameter int unsigned IDLE_DLY   = 25,
  parameter int unsigned WAKE_DLY   = 50,
  parameter int unsigned SETTLE_DLY = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] line_act,
  input  logic           shdn_n,
  input  logic           force_on,
  output logic           status,
  output logic           drv_en,
  output logic           rcv_en,
  output logic           pump_en
);
  import lpc_pkg::*;

  logic [NCH-1:0] act_s;
  logic           any_act, line_up, rails_ok;
  pwr_mode_t      mode;

  act_sync #(.NCH(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(line_act), .synced(act_s));

  assign any_act = |act_s;

  status_filter #(.DLY(STS_DLY)) u_status (
    .clk(clk), .rst_n(rst_n), .any_act(any_act), .status(status));

  line_track #(.IDLE_DLY(IDLE_DLY), .WAKE_DLY(WAKE_DLY)) u_track (
    .clk(clk), .rst_n(rst_n), .any_act(any_act), .line_up(line_up));

  rail_settle #(.DLY(SETTLE_DLY)) u_rails (
    .clk(clk), .rst_n(rst_n), .pwr_on(shdn_n), .rails_ok(rails_ok));

  assign mode = pick_mode(shdn_n, force_on);

  always_comb begin
    rcv_en  = (mode != PM_OFF);
    pump_en = (mode != PM_OFF);
    unique case (mode)
      PM_FORCED: drv_en = rails_ok;
      PM_AUTO:   drv_en = rails_ok && line_up;
      default:   drv_en = 1'b0;
    endcase
  end

  // R6
  drv_needs_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (pump_en && rcv_en));
  // R5
  off_means_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> !(drv_en || rcv_en || pump_en));
  // R10
  drv_needs_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) && !$past(force_on) && $past(shdn_n) |-> $past(rails_ok) || rails_ok);
endmodule

// File: tb/test_line_power_ctrl.sv
`timescale 1ns/1ps
module test_line_power_ctrl;
  localparam int STS = 5, IDLE = 25, WAKE = 50, SET = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] line_act = 3'b000;
  logic       shdn_n = 1'b1, force_on = 1'b0;
  logic       status, drv_en, rcv_en, pump_en;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  line_power_ctrl #(.NCH(3), .STS_DLY(STS), .IDLE_DLY(IDLE), .WAKE_DLY(WAKE),
                    .SETTLE_DLY(SET)) i_line_power_ctrl (
    .clk(clk), .rst_n(rst_n), .line_act(line_act), .shdn_n(shdn_n),
    .force_on(force_on), .status(status), .drv_en(drv_en), .rcv_en(rcv_en),
    .pump_en(pump_en));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%0b expected=%0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic t_reset;
    tick(3);
    rst_n = 1'b1;
    check("R1", "status", status, 1'b0);
    check("R1", "drv_en", drv_en, 1'b0);
    check("R1", "rcv_en", rcv_en, 1'b1);
    check("R1", "pump_en", pump_en, 1'b1);
    tick(SET + 2);
    check("R1", "drv_en standby", drv_en, 1'b0);
  endtask

  task automatic t_forced;
    force_on = 1'b1; shdn_n = 1'b0;
    tick(2);
    check("R5", "drv_en", drv_en, 1'b0);
    check("R5", "rcv_en", rcv_en, 1'b0);
    check("R5", "pump_en", pump_en, 1'b0);
    shdn_n = 1'b1;
    tick(SET - 1);
    check("R10", "drv_en settling", drv_en, 1'b0);
    tick(1);
    check("R6", "drv_en forced", drv_en, 1'b1);
    tick(2 * IDLE + 10);
    check("R6", "drv_en forced quiet", drv_en, 1'b1);
  endtask

  task automatic t_wake;
    force_on = 1'b0; #1;
    check("R9", "drv_en standby", drv_en, 1'b0);
    line_act = 3'b010;
    tick(STS + 1);
    check("R2", "status before", status, 1'b0);
    tick(1);
    check("R2", "status rise", status, 1'b1);
    tick(25 - (STS + 2));
    line_act = 3'b000;
    tick(3);
    line_act = 3'b010;
    tick(WAKE + 1);
    check("R9", "drv_en before wake", drv_en, 1'b0);
    check("R3", "status through dip", status, 1'b1);
    tick(1);
    check("R9", "drv_en wake", drv_en, 1'b1);
  endtask

  task automatic t_idle;
    line_act = 3'b000;
    tick(STS + 1);
    check("R3", "status before fall", status, 1'b1);
    tick(1);
    check("R3", "status fall", status, 1'b0);
    tick(12 - (STS + 2));
    check("R8", "drv_en mid quiet", drv_en, 1'b1);
    line_act = 3'b001;
    tick(2);
    line_act = 3'b000;
    tick(IDLE + 1);
    check("R8", "drv_en quiet restarted", drv_en, 1'b1);
    tick(1);
    check("R7", "drv_en standby", drv_en, 1'b0);
    check("R7", "rcv_en live", rcv_en, 1'b1);
    check("R7", "pump_en live", pump_en, 1'b1);
  endtask

  task automatic t_shutdown;
    shdn_n = 1'b0; force_on = 1'b1; #1;
    check("R5", "drv_en", drv_en, 1'b0);
    check("R5", "rcv_en", rcv_en, 1'b0);
    check("R5", "pump_en", pump_en, 1'b0);
    line_act = 3'b100;
    tick(STS + 1);
    check("R4", "status before", status, 1'b0);
    tick(1);
    check("R4", "status in shutdown", status, 1'b1);
    tick(WAKE + 5);
    force_on = 1'b0; shdn_n = 1'b1;
    tick(SET - 1);
    check("R10", "drv_en settling", drv_en, 1'b0);
    tick(1);
    check("R10", "drv_en settled", drv_en, 1'b1);
    shdn_n = 1'b0; #1;
    check("R5", "drv_en off", drv_en, 1'b0);
    check("R5", "rcv_en off", rcv_en, 1'b0);
    tick(1);
    shdn_n = 1'b1;
    tick(1);
    check("R10", "rails lost", drv_en, 1'b0);
  endtask

  initial begin
    t_reset();
    t_forced();
    t_wake();
    t_idle();
    t_shutdown();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule